// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a four-bank DDR SDRAM interface. It takes the memory from power-up to the idle state before any normal read or write traffic may start. After reset it waits for a `pwr_ok` input that reports stable supplies and a stable clock. It then drives NOP for a hold interval given in microseconds and converted to clock cycles from a clock-frequency parameter. After the hold it issues one precharge to all banks, one extended mode register load, and one mode register load that also requests a DLL reset. It follows these with a programmable number of auto-refresh commands. A fixed settle interval comes last, and then `init_done` rises and stays high.

The mode and extended-mode values arrive on `mr_cfg` and `emr_cfg`. They are captured on the clock edge that accepts `pwr_ok`. Each command other than NOP is driven for exactly one cycle. NOP gaps follow each one, with parameterized lengths for the precharge, mode-load and refresh recovery times. A synchronous reset returns the block to waiting from any point in the sequence.

The controlling state machine has these states:
- WAIT_PWR: idle until `pwr_ok`, then to HOLD.
- HOLD: the NOP hold. When its timer expires it goes to PREA.
- PREA: one cycle, then GAP_RP.
- GAP_RP: on expiry to EMRS.
- EMRS: one cycle, then GAP_EMRD.
- GAP_EMRD: on expiry to MRS.
- MRS: one cycle, then GAP_MRD.
- GAP_MRD: on expiry to REF.
- REF: one cycle, then GAP_RFC.
- GAP_RFC: on expiry, back to REF while refreshes remain, otherwise to SETTLE.
- SETTLE: on expiry to READY.
- READY: terminal state.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows the following. The command pins {cs_n,ras_n,cas_n,we_n} are 0111 (NOP). `ba` is 0, `addr` is 0 and `init_done` is 0. The block again waits for `pwr_ok`, even when the reset came in the middle of a sequence.
- R2: While `pwr_ok` has not been accepted, the pins stay at NOP with `ba` and `addr` zero, and `init_done` stays low.
- R3: Let E be the edge that accepts `pwr_ok` and H = CLK_MHZ*HOLD_US. NOP is driven for H cycles after E. The next cycle carries the precharge-all command: pins 0010, `addr` bit 10 set and every other address bit zero, `ba` 00.
- R4: Exactly T_RP NOP cycles after the precharge, the extended mode load is driven: pins 0000, `ba` 01, `addr` equal to the captured `emr_cfg`.
- R5: Exactly T_MRD NOP cycles after the extended load, the mode load is driven: pins 0000, `ba` 00, `addr` equal to the captured `mr_cfg` with bit 8 (DLL reset) forced to 1.
- R6: The first auto-refresh (pins 0001, `ba` and `addr` zero) comes exactly T_MRD NOP cycles after the mode load. N_REF refreshes are issued, spaced T_RFC+1 cycles apart, and an N_REF below 2 is treated as 2.
- R7: Every non-NOP command lasts exactly one cycle and is followed by NOP. All gap cycles carry NOP with `ba` and `addr` zero.
- R8: After the last refresh and its T_RFC gap, NOP is held for SETTLE_CYC cycles (default 200). `init_done` then rises and stays high, with NOP on the pins, until reset.
- R9: Changes on `mr_cfg` and `emr_cfg` after the accepting edge E have no effect on the loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| pwr_ok | input | 1 | Supplies and clock are stable |
| mr_cfg | input | ADDR_W | Mode register value (burst length, CAS latency) |
| emr_cfg | input | ADDR_W | Extended mode value (DLL enable, drive strength) |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| init_done | output | 1 | Device idle and ready |

## Verification
The in-RTL properties check the following on every cycle:
- a command never repeats into a second cycle;
- the pins stay at NOP while waiting or holding;
- `init_done` is sticky and quiet;
- every mode load requests the DLL reset;
- the refresh count never exceeds its target;
- the extended load is entered only from the precharge gap.

The exact spacing of each command relative to the accepting edge can only be shown by the bench scenarios. The same holds for the number of refreshes, the settle length and the use of values captured at the start despite later input changes. The bench compares the full pin vector of two differently configured instances on every cycle against an arithmetic schedule. It includes a reset in the middle of a sequence.

// File: rtl/ddr_pwrup_pkg.sv
package ddr_pwrup_pkg;

    typedef enum logic [3:0] {
        ST_WAIT_PWR,
        ST_HOLD,
        ST_PREA,
        ST_GAP_RP,
        ST_EMRS,
        ST_GAP_EMRD,
        ST_MRS,
        ST_GAP_MRD,
        ST_REF,
        ST_GAP_RFC,
        ST_SETTLE,
        ST_READY
    } seq_state_t;

    typedef enum logic [2:0] {
        OP_NOP,
        OP_PREA,
        OP_EMRS,
        OP_MRS,
        OP_REF
    } seq_op_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] PINS_NOP  = 4'b0111;
    localparam logic [3:0] PINS_PRE  = 4'b0010;
    localparam logic [3:0] PINS_REF  = 4'b0001;
    localparam logic [3:0] PINS_LOAD = 4'b0000;

endpackage

// File: rtl/ddr_pwrup_timer.sv
module ddr_pwrup_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // Loaded values only count down; a non-zero count decrements by one (R7)
    p_count_down_r7: assert property (@(posedge clk) disable iff (rst)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/ddr_pwrup_cmd_enc.sv
module ddr_pwrup_cmd_enc
    import ddr_pwrup_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int BA_W        = 2,
    parameter int DLL_RST_BIT = 8,
    parameter int ALL_BANK_BIT = 10
) (
    input  seq_op_t            op,
    input  logic [ADDR_W-1:0]  mr_val,
    input  logic [ADDR_W-1:0]  emr_val,
    output logic [3:0]         pins,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr
);
    always_comb begin
        pins = PINS_NOP;
        ba   = '0;
        addr = '0;
        unique case (op)
            OP_PREA: begin
                pins = PINS_PRE;
                addr[ALL_BANK_BIT] = 1'b1;
            end
            OP_EMRS: begin
                pins = PINS_LOAD;
                ba   = BA_W'(1);
                addr = emr_val;
            end
            OP_MRS: begin
                pins = PINS_LOAD;
                addr = mr_val;
                addr[DLL_RST_BIT] = 1'b1;
            end
            OP_REF:  pins = PINS_REF;
            default: pins = PINS_NOP;
        endcase
    end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_pwrup_pkg::*;
#(
    parameter int CLK_MHZ    = 200,
    parameter int HOLD_US    = 200,
    parameter int T_RP       = 3,
    parameter int T_MRD      = 2,
    parameter int T_RFC      = 14,
    parameter int N_REF      = 2,
    parameter int SETTLE_CYC = 200,
    parameter int ADDR_W     = 12,
    parameter int BA_W       = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_ok,
    input  logic [ADDR_W-1:0] mr_cfg,
    input  logic [ADDR_W-1:0] emr_cfg,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int HOLD_CYC  = CLK_MHZ * HOLD_US;
    localparam int N_REF_EFF = (N_REF < 2) ? 2 : N_REF;
    localparam int MAX_A     = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int MAX_B     = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int MAX_C     = (MAX_B > T_RFC) ? MAX_B : T_RFC;
    localparam int MAX_LD    = (MAX_A > MAX_C) ? MAX_A : MAX_C;
    localparam int CNT_W     = (MAX_LD < 2) ? 1 : $clog2(MAX_LD + 1);
    localparam int RC_W      = $clog2(N_REF_EFF + 1);

    localparam logic [CNT_W-1:0] LD_HOLD   = CNT_W'(HOLD_CYC - 1);
    localparam logic [CNT_W-1:0] LD_RP     = CNT_W'(T_RP - 1);
    localparam logic [CNT_W-1:0] LD_MRD    = CNT_W'(T_MRD - 1);
    localparam logic [CNT_W-1:0] LD_RFC    = CNT_W'(T_RFC - 1);
    localparam logic [CNT_W-1:0] LD_SETTLE = CNT_W'(SETTLE_CYC - 1);
    localparam logic [RC_W-1:0]  REF_LAST  = RC_W'(N_REF_EFF);

    seq_state_t         state, nxt;
    seq_op_t            op;
    logic               tmr_load, tmr_expired;
    logic [CNT_W-1:0]   tmr_val;
    logic [RC_W-1:0]    ref_cnt;
    logic [ADDR_W-1:0]  mr_q, emr_q;
    logic [3:0]         pins;

    // state register, refresh tally and configuration capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_WAIT_PWR;
            ref_cnt <= '0;
            mr_q    <= '0;
            emr_q   <= '0;
        end else begin
            state <= nxt;
            if (state == ST_REF)
                ref_cnt <= ref_cnt + 1'b1;
            if (state == ST_WAIT_PWR && pwr_ok) begin
                mr_q  <= mr_cfg;
                emr_q <= emr_cfg;
            end
        end
    end

    // transitions and timer loads
    always_comb begin
        nxt      = state;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_WAIT_PWR: if (pwr_ok) begin
                nxt = ST_HOLD; tmr_load = 1'b1; tmr_val = LD_HOLD;
            end
            ST_HOLD:     if (tmr_expired) nxt = ST_PREA;
            ST_PREA: begin
                nxt = ST_GAP_RP; tmr_load = 1'b1; tmr_val = LD_RP;
            end
            ST_GAP_RP:   if (tmr_expired) nxt = ST_EMRS;
            ST_EMRS: begin
                nxt = ST_GAP_EMRD; tmr_load = 1'b1; tmr_val = LD_MRD;
            end
            ST_GAP_EMRD: if (tmr_expired) nxt = ST_MRS;
            ST_MRS: begin
                nxt = ST_GAP_MRD; tmr_load = 1'b1; tmr_val = LD_MRD;
            end
            ST_GAP_MRD:  if (tmr_expired) nxt = ST_REF;
            ST_REF: begin
                nxt = ST_GAP_RFC; tmr_load = 1'b1; tmr_val = LD_RFC;
            end
            ST_GAP_RFC: if (tmr_expired) begin
                if (ref_cnt == REF_LAST) begin
                    nxt = ST_SETTLE; tmr_load = 1'b1; tmr_val = LD_SETTLE;
                end else begin
                    nxt = ST_REF;
                end
            end
            ST_SETTLE:   if (tmr_expired) nxt = ST_READY;
            ST_READY:    nxt = ST_READY;
            default:     nxt = ST_WAIT_PWR;
        endcase
    end

    // outputs from state
    always_comb begin
        op = OP_NOP;
        unique case (state)
            ST_PREA: op = OP_PREA;
            ST_EMRS: op = OP_EMRS;
            ST_MRS:  op = OP_MRS;
            ST_REF:  op = OP_REF;
            default: op = OP_NOP;
        endcase
        init_done = (state == ST_READY);
    end

    ddr_pwrup_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    ddr_pwrup_cmd_enc #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_enc (
        .op      (op),
        .mr_val  (mr_q),
        .emr_val (emr_q),
        .pins    (pins),
        .ba      (ba),
        .addr    (addr)
    );

    assign {cs_n, ras_n, cas_n, we_n} = pins;

    // R2/R3: nothing but NOP while waiting or holding
    p_wait_nop_r2: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_PWR || state == ST_HOLD) |-> (pins == PINS_NOP));

    // R4: extended load is only entered from the precharge gap
    p_emrs_after_pre_r4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EMRS) |-> ($past(state) == ST_GAP_RP));

    // R5: a mode load on bank 0 always asks for DLL reset
    p_mrs_dll_r5: assert property (@(posedge clk) disable iff (rst)
        (pins == PINS_LOAD && ba == '0) |-> addr[8]);

    // R6: refresh tally never exceeds its target
    p_ref_bound_r6: assert property (@(posedge clk) disable iff (rst)
        ref_cnt <= REF_LAST);

    // R7: a non-NOP command never lasts into a second cycle
    p_cmd_single_r7: assert property (@(posedge clk) disable iff (rst)
        (pins != PINS_NOP) |=> (pins == PINS_NOP));

    // R8: ready is sticky and quiet
    p_ready_sticky_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |=> init_done);
    p_ready_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        init_done |-> (pins == PINS_NOP && addr == '0));
endmodule

// File: tb/ddr_pwrup_seq_bench.sv
module ddr_pwrup_seq_bench;
    timeunit 1ns;
    timeprecision 1ps;

    // configuration A
    localparam int A_H = 6, A_RP = 2, A_MRD = 2, A_RFC = 4, A_NREF = 2, A_ST = 200;
    // configuration B
    localparam int B_H = 5, B_RP = 1, B_MRD = 1, B_RFC = 1, B_NREF = 3, B_ST = 200;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pwr_ok = 1'b0;
    logic [11:0] mr_cfg = '0, emr_cfg = '0;

    logic a_cs, a_ras, a_cas, a_we, a_done;
    logic [1:0] a_ba;
    logic [11:0] a_addr;
    logic b_cs, b_ras, b_cas, b_we, b_done;
    logic [1:0] b_ba;
    logic [11:0] b_addr;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ddr_pwrup_seq #(.CLK_MHZ(2), .HOLD_US(3), .T_RP(A_RP), .T_MRD(A_MRD),
                    .T_RFC(A_RFC), .N_REF(A_NREF), .SETTLE_CYC(A_ST)) u_ddr_pwrup_seq (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .mr_cfg(mr_cfg), .emr_cfg(emr_cfg),
        .cs_n(a_cs), .ras_n(a_ras), .cas_n(a_cas), .we_n(a_we),
        .ba(a_ba), .addr(a_addr), .init_done(a_done));

    ddr_pwrup_seq #(.CLK_MHZ(1), .HOLD_US(5), .T_RP(B_RP), .T_MRD(B_MRD),
                    .T_RFC(B_RFC), .N_REF(B_NREF), .SETTLE_CYC(B_ST)) u_ddr_pwrup_seq_b (
        .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .mr_cfg(mr_cfg), .emr_cfg(emr_cfg),
        .cs_n(b_cs), .ras_n(b_ras), .cas_n(b_cas), .we_n(b_we),
        .ba(b_ba), .addr(b_addr), .init_done(b_done));

    function automatic logic [18:0] vec_a();
        return {a_done, a_cs, a_ras, a_cas, a_we, a_ba, a_addr};
    endfunction
    function automatic logic [18:0] vec_b();
        return {b_done, b_cs, b_ras, b_cas, b_we, b_ba, b_addr};
    endfunction

    localparam logic [18:0] IDLE_VEC = {1'b0, 4'b0111, 2'b00, 12'h000};

    function automatic int done_at(int h, int rp, int mrd, int rfc, int nref, int st);
        int r0 = h + rp + 1 + mrd + 1 + mrd + 1;
        return r0 + (nref - 1) * (rfc + 1) + rfc + 1 + st;
    endfunction

    task automatic check_vec(string who, string tag, logic [18:0] act, logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
        end
    endtask

    // schedule relative to the accepting edge, i = cycles after it
    task automatic check_sched(string who, int i, int h, int rp, int mrd, int rfc,
                               int nref, int st, logic [11:0] mr, logic [11:0] emr,
                               logic [18:0] act);
        int e  = h + rp + 1;
        int m  = e + mrd + 1;
        int r0 = m + mrd + 1;
        int last = r0 + (nref - 1) * (rfc + 1);
        int d  = done_at(h, rp, mrd, rfc, nref, st);
        logic [18:0] exp = IDLE_VEC;
        string tag = "R7";
        if (i < h) tag = "R3";
        else if (i == h) begin exp = {1'b0, 4'b0010, 2'b00, 12'h400}; tag = "R3"; end
        else if (i == e) begin exp = {1'b0, 4'b0000, 2'b01, emr}; tag = "R4 R9"; end
        else if (i == m) begin exp = {1'b0, 4'b0000, 2'b00, mr | 12'h100}; tag = "R5 R9"; end
        else if (i >= r0 && i <= last && ((i - r0) % (rfc + 1)) == 0) begin
            exp = {1'b0, 4'b0001, 2'b00, 12'h000}; tag = "R6";
        end
        else if (i >= d) begin exp = {1'b1, 4'b0111, 2'b00, 12'h000}; tag = "R8"; end
        else if (i > last + rfc) tag = "R8";
        check_vec(who, tag, act, exp);
    endtask

    // one sequence; abort >= 0 applies reset at that cycle
    task automatic run_seq(logic [11:0] mr, logic [11:0] emr, bit change_mid, int abort);
        int len_a = done_at(A_H, A_RP, A_MRD, A_RFC, A_NREF, A_ST);
        int len_b = done_at(B_H, B_RP, B_MRD, B_RFC, B_NREF, B_ST);
        int len = ((len_a > len_b) ? len_a : len_b) + 6;
        pwr_ok  = 1'b1;
        mr_cfg  = mr;
        emr_cfg = emr;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            check_sched("cfgA", i, A_H, A_RP, A_MRD, A_RFC, A_NREF, A_ST, mr, emr, vec_a());
            check_sched("cfgB", i, B_H, B_RP, B_MRD, B_RFC, B_NREF, B_ST, mr, emr, vec_b());
            if (change_mid && i == 1) begin
                mr_cfg  = ~mr;
                emr_cfg = ~emr;
            end
            if (i == abort) begin
                rst = 1'b1;
                pwr_ok = 1'b0;
                return;
            end
        end
        rst = 1'b1;
        pwr_ok = 1'b0;
    endtask

    task automatic after_reset(int idle_cycles);
        @(negedge clk);
        check_vec("cfgA", "R1", vec_a(), IDLE_VEC);
        check_vec("cfgB", "R1", vec_b(), IDLE_VEC);
        rst = 1'b0;
        for (int k = 0; k < idle_cycles; k++) begin
            @(negedge clk);
            check_vec("cfgA", "R2", vec_a(), IDLE_VEC);
            check_vec("cfgB", "R2", vec_b(), IDLE_VEC);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        after_reset(8);
        run_seq(12'h062, 12'h002, 1'b1, -1);      // R9: inputs flipped mid-run
        after_reset(3);
        run_seq(12'h1A5, 12'h000, 1'b0, A_H + 4); // R1: reset mid-sequence
        after_reset(5);
        run_seq(12'hE3B, 12'h5C1, 1'b0, -1);
        after_reset(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule